// File: doc/BRIEF.md
# Programmable-Length Serial Peripheral Master

This block is the host-side engine of a four-wire synchronous serial link. For each start strobe it shifts one word of 1 to 64 bits to a target device and brings back the word the device returns. The host chooses the clock polarity and phase, the bit count, the clock half-period in system cycles, and which of four active-low selects to drive. The received word is right-aligned in `rx_data` and is marked by a one-cycle `done` pulse.

A `hold_cs` flag, sampled with the start strobe, keeps the select low after `done`. The next start then continues the same frame, which lets a command word and a response word of different lengths share one selection. Before each word the master waits for an active-low ready line from the target and issues no clock edge until that line is low. A target without such a line has it tied low.

Top module: `spi_word_master`

## Requirements
- R1: `mode[1]` sets the clock polarity and `mode[0]` sets the phase. The serial clock rests at the polarity level. It reaches that level one system cycle before any select goes low, and it is back there when `done` rises.
- R2: With phase 0, the first data bit is on `mosi` at least one half-period before the first clock edge. Both ends sample on each leading edge, and data changes on each trailing edge.
- R3: With phase 1, data changes on each leading edge and both ends sample on each trailing edge.
- R4: `nbits` holds the word length minus one, so 0 to 63 means 1 to 64 bits. The low `nbits+1` bits of `tx_data` go out most significant bit first. The word sampled from `miso` appears in the low bits of `rx_data`, first bit received at the highest of those positions, and every bit above is zero.
- R5: A word produces exactly 2·N serial clock edges, one every D system cycles, where D is `div` and a `div` of zero counts as 1. With no ready stall, `done` is high for exactly one cycle. Counting the edge that accepts `start` as edge 1, `done` is first seen high after edge 3+(2N+1)·D.
- R6: The select driven low is the lowest set bit of `cs_sel`, so `cs_sel`=4'b1010 drives `cs_n`=4'b1101. Never more than one select is low.
- R7: When `done` rises, all selects go high unless `hold_cs` was set with the start. If it was set, the select stays low through idle and into the next word.
- R8: While `rdy_n` is high before a word, the serial clock holds its rest level and no edge is issued, with the select already low. Once `rdy_n` is low the word runs normally.
- R9: A start strobe during a transfer is ignored, and the running word's data, length and timing are unaffected.
- R10: After reset, `sclk`=0, `mosi`=0, `cs_n`=4'b1111, `done`=0 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one word when idle |
| mode | input | 2 | {polarity, phase} |
| nbits | input | 6 | Word length minus one |
| cs_sel | input | 4 | Select request, lowest set bit wins |
| hold_cs | input | 1 | Keep select low after this word |
| div | input | 16 | Half-period in system cycles (0 means 1) |
| tx_data | input | 64 | Word to send, right-aligned |
| rx_data | output | 64 | Received word, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to target |
| cs_n | output | 4 | Active-low selects |
| miso | input | 1 | Serial data from target |
| rdy_n | input | 1 | Active-low target ready |

## Verification
The hardest situations to reach are those in which state crosses the gap between two words. One is a held select carried into a second word with a different length. Another is a start strobe that arrives while a word is still in flight. The bench models the target as an event-driven shift register that follows the selected phase rule. It chains a held word into a second word and checks the select level during the idle gap between them. It also pulses `start` with conflicting inputs partway through a word, then confirms that the length, the data in both directions and the cycle count match the original request.

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int LW   = 6,
  parameter int DIVW = 16,
  parameter int NSEL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [LW-1:0]     nbits,
  input  logic [NSEL-1:0]   cs_sel,
  input  logic              hold_cs,
  input  logic [DIVW-1:0]   div,
  input  logic [(1<<LW)-1:0] tx_data,
  output logic [(1<<LW)-1:0] rx_data,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  output logic [NSEL-1:0]   cs_n,
  input  logic              miso,
  input  logic              rdy_n
);
  localparam int MAXW = 1 << LW;
  localparam logic [LW-1:0] TOP = LW'(MAXW - 1);

  typedef enum logic [2:0] {IDLE, PREP, READY, RUN, TAIL} st_t;

  st_t             st;
  logic            cpol_q, cpha_q, hold_q;
  logic [LW-1:0]   nb_q;
  logic [DIVW-1:0] dv_q, cnt;
  logic [LW:0]     ecnt;
  logic [MAXW-1:0] sh;
  logic [NSEL-1:0] sel_q, cs_q;

  wire [NSEL-1:0] sel_low = cs_sel & (~cs_sel + 1'b1);
  wire [DIVW-1:0] div_eff = (div == '0) ? DIVW'(1) : div;
  wire            tick    = (cnt == '0);
  wire            lead    = ~ecnt[0];
  wire            samp    = lead ^ cpha_q;
  wire            last    = (ecnt == {nb_q, 1'b1});
  wire [MAXW-1:0] rmask   = {MAXW{1'b1}} >> (TOP - nb_q);

  assign cs_n = ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      hold_q <= 1'b0;
      nb_q <= '0;
      dv_q <= DIVW'(1);
      cnt <= '0;
      ecnt <= '0;
      sh <= '0;
      sel_q <= '0;
      cs_q <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      rx_data <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          cpol_q <= mode[1];
          cpha_q <= mode[0];
          hold_q <= hold_cs;
          nb_q   <= nbits;
          dv_q   <= div_eff;
          sel_q  <= sel_low;
          sh     <= tx_data << (TOP - nbits);
          mosi   <= tx_data[nbits];
          sclk   <= mode[1];
          st     <= PREP;
        end
        PREP: begin
          cs_q <= sel_q;
          st   <= READY;
        end
        READY: if (!rdy_n) begin
          cnt  <= dv_q - 1'b1;
          ecnt <= '0;
          st   <= RUN;
        end
        RUN: if (tick) begin
          sclk <= ~sclk;
          if (samp) sh <= {sh[MAXW-2:0], miso};
          else      mosi <= sh[MAXW-1];
          ecnt <= ecnt + 1'b1;
          cnt  <= dv_q - 1'b1;
          if (last) st <= TAIL;
        end else begin
          cnt <= cnt - 1'b1;
        end
        TAIL: if (tick) begin
          done    <= 1'b1;
          rx_data <= sh & rmask;
          if (!hold_q) cs_q <= '0;
          st <= IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
    (st == READY) |-> (sclk == cpol_q));

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == READY && rdy_n) |=> ($stable(sclk) && st == READY));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hold_q) |-> (&cs_n));

  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE) |=> ($stable(nb_q) && $stable(dv_q) && $stable(cpha_q)));
endmodule

// File: tb/sim_spi_word_master.sv
module sim_spi_word_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [5:0]  nbits = 6'd0;
  logic [3:0]  cs_sel = 4'd1;
  logic        hold_cs = 1'b0;
  logic [15:0] div = 16'd1;
  logic [63:0] tx_data = '0;
  logic [63:0] rx_data;
  logic        done, sclk, mosi;
  logic [3:0]  cs_n;
  logic        miso = 1'b0;
  logic        rdy_n = 1'b0;

  int tests = 0, fails = 0, gcyc = 0;

  spi_word_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .nbits(nbits),
    .cs_sel(cs_sel), .hold_cs(hold_cs), .div(div), .tx_data(tx_data),
    .rx_data(rx_data), .done(done), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .rdy_n(rdy_n)
  );

  always #4 clk = ~clk;

  // target model
  logic        s_cpol = 1'b0, s_cpha = 1'b0;
  logic [63:0] s_word = '0, s_rx = '0;
  int          s_k = 0, edges = 0;

  always @(sclk) begin
    if (rst_n && cs_n != 4'hF) begin
      if ((sclk != s_cpol) ^ s_cpha) s_rx = {s_rx[62:0], mosi};
      else begin
        if (s_k >= 0) miso = s_word[s_k];
        s_k = s_k - 1;
      end
      edges = edges + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_of(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [3:0] low_of(input logic [3:0] s);
    for (int i = 0; i < 4; i++) if (s[i]) return 4'(1 << i);
    return 4'd0;
  endfunction

  bit held = 1'b0;

  task automatic word(input logic [1:0] md, input int n, input logic [3:0] sel,
                      input bit hold, input logic [15:0] dv, input logic [63:0] tx,
                      input logic [63:0] sw, input int stall, input bit poke);
    int cyc, d, expc;
    logic [3:0] lo;
    lo = low_of(sel);
    d = (dv == 0) ? 1 : int'(dv);
    s_cpol = md[1]; s_cpha = md[0]; s_word = sw; s_rx = '0; edges = 0;
    if (!md[0]) begin miso = sw[n-1]; s_k = n - 2; end
    else s_k = n - 1;
    @(negedge clk);
    mode = md; nbits = 6'(n - 1); cs_sel = sel; hold_cs = hold; div = dv;
    tx_data = tx; start = 1'b1; rdy_n = (stall > 0);
    cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
      start = 1'b0;
      if (cyc == 1) begin
        chk(sclk == md[1], "R1", "rest level before select", 64'(sclk), 64'(md[1]));
        if (!held) chk(cs_n == 4'hF, "R1", "select still high at clock set", 64'(cs_n), 64'hF);
      end
      if (cyc == 5 && stall == 0)
        chk(cs_n == ~lo, "R6", "selected line", 64'(cs_n), 64'(~lo));
      if (stall > 0 && cyc == stall) begin
        chk(sclk == md[1] && edges == 0, "R8", "no edges while not ready",
            64'(edges), 64'd0);
        chk(cs_n == ~lo, "R8", "select low during stall", 64'(cs_n), 64'(~lo));
        rdy_n = 1'b0;
      end
      if (poke && cyc == 6) begin
        start = 1'b1; tx_data = ~tx; nbits = 6'd0; div = 16'd7; mode = ~md;
      end
    end while (!done && cyc < 20000);
    expc = 3 + (2*n + 1)*d + ((stall >= 3) ? stall - 2 : 0);
    chk(rx_data == (sw & mask_of(n)), md[0] ? "R3" : "R2", "received word (R4)",
        rx_data, sw & mask_of(n));
    chk((s_rx & mask_of(n)) == (tx & mask_of(n)), md[0] ? "R3" : "R2",
        "target saw word (R4)", s_rx & mask_of(n), tx & mask_of(n));
    chk(edges == 2*n, "R5", "edge count", 64'(edges), 64'(2*n));
    chk(cyc == expc, poke ? "R9" : "R5", "done latency", 64'(cyc), 64'(expc));
    chk(sclk == md[1], "R1", "rest level at done", 64'(sclk), 64'(md[1]));
    chk(cs_n == (hold ? ~lo : 4'hF), "R7", "select after done", 64'(cs_n),
        64'(hold ? ~lo : 4'hF));
    @(negedge clk);
    chk(done == 1'b0, "R5", "done one cycle", 64'(done), 64'd0);
    held = hold;
  endtask

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected < 150000", gcyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  int lens[8] = '{1, 2, 3, 7, 8, 12, 31, 64};

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sclk == 0 && mosi == 0, "R10", "clock and data after reset",
        64'({sclk, mosi}), 64'd0);
    chk(cs_n == 4'hF && done == 0, "R10", "select and done after reset",
        64'({cs_n, done}), 64'h1E);
    chk(rx_data == '0, "R10", "read data after reset", rx_data, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int m = 0; m < 4; m++)
      for (int li = 0; li < 8; li++)
        for (int dv = 1; dv <= 3; dv++) begin
          int k;
          k = m*24 + li*3 + dv;
          word(2'(m), lens[li], 4'(1 << (k % 4)), 1'b0, 16'(dv),
               {32'h9E3779B9 * 32'(k + 1), 32'h7F4A7C15 ^ 32'(k * 977)},
               {32'hC2B2AE35 ^ 32'(k * 31), 32'h85EBCA6B * 32'(k + 3)},
               0, 1'b0);
        end

    // R5 zero divider counts as one
    word(2'd1, 9, 4'd2, 1'b0, 16'd0, 64'h1A5, 64'h0F3, 0, 1'b0);
    // R6 several select bits: lowest wins
    word(2'd0, 8, 4'b1010, 1'b0, 16'd2, 64'hC3, 64'h5A, 0, 1'b0);
    // R7 held select chains a command into a response of another length
    word(2'd3, 8, 4'd8, 1'b1, 16'd2, 64'h9B, 64'h00, 0, 1'b0);
    repeat (6) @(negedge clk);
    chk(cs_n == 4'b0111, "R7", "select held across idle gap", 64'(cs_n), 64'h7);
    word(2'd3, 21, 4'd8, 1'b0, 16'd1, 64'h0, 64'h1ABCDE, 0, 1'b0);
    // R8 ready stall
    word(2'd2, 13, 4'd4, 1'b0, 16'd2, 64'h1F0F, 64'h0AAA, 12, 1'b0);
    // R9 start pulsed mid-transfer
    word(2'd1, 16, 4'd1, 1'b0, 16'd3, 64'hBEEF, 64'h1234, 0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule